// File: doc/BRIEF.md
# Five-Stage Integer Pipeline Core

This block is a 32-bit in-order integer core built as five stages: fetch, decode with register read, execute, memory access and write-back. A pipeline register sits between each pair of stages. The core executes twelve operations: six register-register ALU operations, an add-immediate, a word load and store, branches on a register being zero or non-zero, and a PC-relative jump. It has one port for instruction memory and a separate port for data memory. The register file holds 32 words, and register 0 is fixed at zero.

There are no interlocks, no forwarding paths and no flush. The program has to space its instructions. A consumer must come at least three slots after its producer, so two filler words sit between them. Branch and jump outcomes are held in the execute/memory register, and the PC is redirected from there. The three words fetched after a branch or jump are therefore always executed. Both memory ports are fixed-latency combinational reads. There is no valid/ready handshake and no back-pressure. Every cycle fetches one word, and a load's data must be present in the same cycle its address is driven.

Instruction fields are numbered from bit 31 down: opcode [31:26], first source [25:21], second field [20:16], register-type destination [15:11], function [5:0], immediate [15:0], jump offset [25:0].

Top module: `pipe_core`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0 and neither `dmem_we` nor `dmem_re` is asserted. The first fetch after reset is from address 0.
- R2: Without a redirect, `imem_addr` advances by 4 every clock cycle and stays word aligned.
- R3: Opcode 0 selects register-type operations by function code: ADD 0x20, SUB 0x22, AND 0x24, OR 0x25, XOR 0x26, SLT 0x2A. The result goes to the register in bits [15:11], and the operands come from [25:21] and [20:16].
- R4: SLT compares two's-complement values. It writes 1 when the first operand is less than the second and 0 otherwise.
- R5: ADDI (opcode 0x08) adds the sign-extended 16-bit immediate to the register in [25:21]. It writes the sum to the register in [20:16].
- R6: LW (0x23) and SW (0x2B) use the address register[25:21] plus the sign-extended immediate. SW drives `dmem_we`, the address and register[20:16] three cycles after it is fetched. LW writes the read word to register[20:16].
- R7: BEQZ (0x04) and BNEZ (0x05) test register[25:21] for zero or non-zero. When taken, the branch redirects fetch to its own address + 4 + sign-extended immediate. The target is the fourth fetch after the branch, and the three words in between are executed.
- R8: J (0x02) always redirects to its own address + 4 + the sign-extended 26-bit offset, with the same three-slot timing.
- R9: Register 0 reads as zero, and writes to it are discarded.
- R10: A register written back in a cycle is seen by an instruction reading it in decode in that same cycle. Two filler words between producer and consumer are enough.
- R11: A word with an unassigned opcode or function code writes no register and no memory. The all-zero word is such a filler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 32 | Fetch address (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Data memory address |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe |
| dmem_re | output | 1 | Load strobe |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, same cycle |

## Verification
The hardest cases to reach are those that depend on exact spacing. The first is a write-back landing in the very cycle the consumer reads the register. The second is a redirect arriving while the three following slots hold real instructions. The only way to reach them from the ports is a program whose spacing is fixed word by word. The stimulus program places a consumer exactly two fillers after its producer. It puts a live ADDI in a taken branch's first slot and a skipped ADDI just before the target. It also runs a backward counting loop, so the redirect fires repeatedly while fall-through occurs once. A behavioural instruction model in the bench predicts every fetch address and every store, each in its own cycle.

// File: rtl/pipe_pkg.sv
`timescale 1ns/1ps
package pipe_pkg;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_J     = 6'h02;
  localparam logic [5:0] OP_BEQZ  = 6'h04;
  localparam logic [5:0] OP_BNEZ  = 6'h05;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLT
  } alu_op_e;

  typedef enum logic [1:0] {
    BR_NONE, BR_EQZ, BR_NEZ, BR_ALWAYS
  } br_kind_e;

  typedef struct packed {
    alu_op_e  alu_op;
    logic     use_imm;
    logic     rf_wr;
    logic     mem_rd;
    logic     mem_wr;
    br_kind_e br;
  } ctrl_t;

endpackage

// File: rtl/pipe_decode.sv
`timescale 1ns/1ps
module pipe_decode
  import pipe_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RIDX = 5
) (
  input  logic [31:0]      ir,
  output ctrl_t            ctrl,
  output logic [RIDX-1:0]  rs1,
  output logic [RIDX-1:0]  rs2,
  output logic [RIDX-1:0]  wr_idx,
  output logic [XLEN-1:0]  imm
);
  localparam int IMM_W = 16;
  localparam int JOF_W = 26;

  logic [5:0] op;
  logic [5:0] fn;
  logic       unused_shamt;

  assign op           = ir[31:26];
  assign fn           = ir[5:0];
  assign unused_shamt = ^ir[10:6];

  assign rs1    = RIDX'(ir[25:21]);
  assign rs2    = RIDX'(ir[20:16]);
  assign wr_idx = (op == OP_RTYPE) ? RIDX'(ir[15:11]) : RIDX'(ir[20:16]);

  always_comb begin
    if (op == OP_J) imm = {{(XLEN-JOF_W){ir[25]}}, ir[JOF_W-1:0]};
    else            imm = {{(XLEN-IMM_W){ir[15]}}, ir[IMM_W-1:0]};
  end

  always_comb begin
    ctrl = '0;
    unique case (op)
      OP_RTYPE: begin
        ctrl.rf_wr = 1'b1;
        unique case (fn)
          FN_ADD:  ctrl.alu_op = ALU_ADD;
          FN_SUB:  ctrl.alu_op = ALU_SUB;
          FN_AND:  ctrl.alu_op = ALU_AND;
          FN_OR:   ctrl.alu_op = ALU_OR;
          FN_XOR:  ctrl.alu_op = ALU_XOR;
          FN_SLT:  ctrl.alu_op = ALU_SLT;
          default: ctrl.rf_wr  = 1'b0;
        endcase
      end
      OP_ADDI: begin
        ctrl.use_imm = 1'b1;
        ctrl.rf_wr   = 1'b1;
      end
      OP_LW: begin
        ctrl.use_imm = 1'b1;
        ctrl.rf_wr   = 1'b1;
        ctrl.mem_rd  = 1'b1;
      end
      OP_SW: begin
        ctrl.use_imm = 1'b1;
        ctrl.mem_wr  = 1'b1;
      end
      OP_BEQZ: ctrl.br = BR_EQZ;
      OP_BNEZ: ctrl.br = BR_NEZ;
      OP_J:    ctrl.br = BR_ALWAYS;
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/pipe_regfile.sv
`timescale 1ns/1ps
module pipe_regfile #(
  parameter  int XLEN = 32,
  parameter  int NREG = 32,
  parameter  int NRD  = 2,
  localparam int AW   = $clog2(NREG)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  logic [AW-1:0]             waddr,
  input  logic [XLEN-1:0]           wdata,
  input  logic [NRD-1:0][AW-1:0]    raddr,
  output logic [NRD-1:0][XLEN-1:0]  rdata
);
  logic [XLEN-1:0] regs [NREG];
  logic            wr_live;

  assign wr_live = we && (waddr != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_live) begin
      regs[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = (raddr[g] == '0)                  ? '0    :
                      (wr_live && (waddr == raddr[g]))  ? wdata :
                                                          regs[raddr[g]];
  end

endmodule

// File: rtl/pipe_alu.sv
`timescale 1ns/1ps
module pipe_alu
  import pipe_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e          op,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  output logic [XLEN-1:0]  y
);
  logic lt;
  assign lt = $signed(a) < $signed(b);

  always_comb begin
    unique case (op)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, lt};
      default: y = a + b;
    endcase
  end

endmodule

// File: rtl/pipe_core.sv
`timescale 1ns/1ps
module pipe_core
  import pipe_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          NREG     = 32,
  parameter logic [31:0] PC_RESET = 32'h0
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [XLEN-1:0]  imem_addr,
  input  logic [31:0]      imem_rdata,
  output logic [XLEN-1:0]  dmem_addr,
  output logic [XLEN-1:0]  dmem_wdata,
  output logic             dmem_we,
  output logic             dmem_re,
  input  logic [XLEN-1:0]  dmem_rdata
);
  localparam int RIDX   = $clog2(NREG);
  localparam int NRD    = 2;
  localparam int IWORDB = 4;

  // ---------------- fetch ----------------
  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] if_seq;
  logic [31:0]     ifd_ir;
  logic [XLEN-1:0] ifd_npc;

  // ---------------- decode ----------------
  ctrl_t           id_ctrl;
  logic [RIDX-1:0] id_rs1, id_rs2, id_wr_idx;
  logic [XLEN-1:0] id_imm, id_a, id_b;
  logic [NRD-1:0][XLEN-1:0] rf_rd;

  ctrl_t           idx_ctrl;
  logic [XLEN-1:0] idx_a, idx_b, idx_imm, idx_npc;
  logic [RIDX-1:0] idx_wr_idx;

  // ---------------- execute ----------------
  logic [XLEN-1:0] ex_opb, alu_y, ex_tgt, ex_res;
  logic            ex_cond, ex_is_slt;

  logic            exm_cond, exm_rf_wr, exm_mem_rd, exm_mem_wr;
  logic [XLEN-1:0] exm_alu, exm_b;
  logic [RIDX-1:0] exm_wr_idx;

  // ---------------- memory / write-back ----------------
  logic            mwb_rf_wr, mwb_is_ld;
  logic [XLEN-1:0] mwb_alu, mwb_lmd, wb_data;
  logic [RIDX-1:0] mwb_wr_idx;

  // IF
  assign imem_addr = pc_q;
  assign if_seq    = pc_q + XLEN'(IWORDB);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q    <= XLEN'(PC_RESET);
      ifd_ir  <= '0;
      ifd_npc <= '0;
    end else begin
      pc_q    <= exm_cond ? exm_alu : if_seq;
      ifd_ir  <= imem_rdata;
      ifd_npc <= if_seq;
    end
  end

  // ID
  pipe_decode #(.XLEN(XLEN), .RIDX(RIDX)) u_dec (
    .ir     (ifd_ir),
    .ctrl   (id_ctrl),
    .rs1    (id_rs1),
    .rs2    (id_rs2),
    .wr_idx (id_wr_idx),
    .imm    (id_imm)
  );

  pipe_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(NRD)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (mwb_rf_wr),
    .waddr (mwb_wr_idx),
    .wdata (wb_data),
    .raddr ({id_rs2, id_rs1}),
    .rdata (rf_rd)
  );

  assign id_a = rf_rd[0];
  assign id_b = rf_rd[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_ctrl   <= '0;
      idx_a      <= '0;
      idx_b      <= '0;
      idx_imm    <= '0;
      idx_npc    <= '0;
      idx_wr_idx <= '0;
    end else begin
      idx_ctrl   <= id_ctrl;
      idx_a      <= id_a;
      idx_b      <= id_b;
      idx_imm    <= id_imm;
      idx_npc    <= ifd_npc;
      idx_wr_idx <= id_wr_idx;
    end
  end

  // EX
  assign ex_opb    = idx_ctrl.use_imm ? idx_imm : idx_b;
  assign ex_is_slt = (idx_ctrl.alu_op == ALU_SLT) && idx_ctrl.rf_wr && !idx_ctrl.use_imm;

  pipe_alu #(.XLEN(XLEN)) u_alu (
    .op (idx_ctrl.alu_op),
    .a  (idx_a),
    .b  (ex_opb),
    .y  (alu_y)
  );

  assign ex_tgt = idx_npc + idx_imm;

  always_comb begin
    unique case (idx_ctrl.br)
      BR_EQZ:    ex_cond = (idx_a == '0);
      BR_NEZ:    ex_cond = (idx_a != '0);
      BR_ALWAYS: ex_cond = 1'b1;
      default:   ex_cond = 1'b0;
    endcase
  end

  assign ex_res = (idx_ctrl.br != BR_NONE) ? ex_tgt : alu_y;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exm_cond   <= 1'b0;
      exm_rf_wr  <= 1'b0;
      exm_mem_rd <= 1'b0;
      exm_mem_wr <= 1'b0;
      exm_alu    <= '0;
      exm_b      <= '0;
      exm_wr_idx <= '0;
    end else begin
      exm_cond   <= ex_cond;
      exm_rf_wr  <= idx_ctrl.rf_wr;
      exm_mem_rd <= idx_ctrl.mem_rd;
      exm_mem_wr <= idx_ctrl.mem_wr;
      exm_alu    <= ex_res;
      exm_b      <= idx_b;
      exm_wr_idx <= idx_wr_idx;
    end
  end

  // MEM
  assign dmem_addr  = exm_alu;
  assign dmem_wdata = exm_b;
  assign dmem_we    = exm_mem_wr;
  assign dmem_re    = exm_mem_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mwb_rf_wr  <= 1'b0;
      mwb_is_ld  <= 1'b0;
      mwb_alu    <= '0;
      mwb_lmd    <= '0;
      mwb_wr_idx <= '0;
    end else begin
      mwb_rf_wr  <= exm_rf_wr;
      mwb_is_ld  <= exm_mem_rd;
      mwb_alu    <= exm_alu;
      mwb_lmd    <= dmem_rdata;
      mwb_wr_idx <= exm_wr_idx;
    end
  end

  // WB
  assign wb_data = mwb_is_ld ? mwb_lmd : mwb_alu;

endmodule

// File: rtl/pipe_core_chk.sv
`timescale 1ns/1ps
module pipe_core_chk #(
  parameter int XLEN = 32,
  parameter int RIDX = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [XLEN-1:0]  imem_addr,
  input logic             redir,
  input logic [XLEN-1:0]  redir_tgt,
  input logic             dmem_we,
  input logic             dmem_re,
  input logic [RIDX-1:0]  rd_idx,
  input logic [XLEN-1:0]  rd_val,
  input logic             slt_sel,
  input logic [XLEN-1:0]  alu_y
);
  logic ran_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ran_q <= 1'b0;
    else        ran_q <= 1'b1;
  end

  AST_FETCH_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    imem_addr[1:0] == 2'b00);                                          // R2

  AST_FETCH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ran_q && !$past(redir)) |-> (imem_addr == $past(imem_addr) + XLEN'(4))); // R2

  AST_REDIRECT_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (ran_q && $past(redir)) |-> (imem_addr == $past(redir_tgt)));      // R7

  AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == '0) |-> (rd_val == '0));                                // R9

  AST_SLT_BOOLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    slt_sel |-> (alu_y[XLEN-1:1] == '0));                              // R4

  AST_MEM_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dmem_we, dmem_re}));                                     // R6

endmodule

bind pipe_core pipe_core_chk #(.XLEN(XLEN), .RIDX(RIDX)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .imem_addr (imem_addr),
  .redir     (exm_cond),
  .redir_tgt (exm_alu),
  .dmem_we   (dmem_we),
  .dmem_re   (dmem_re),
  .rd_idx    (id_rs1),
  .rd_val    (id_a),
  .slt_sel   (ex_is_slt),
  .alu_y     (alu_y)
);

// File: tb/tb_pipe_core.sv
`timescale 1ns/1ps
module tb_pipe_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_rdata;
  logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dmem_re;

  always #5 clk = ~clk;

  logic [31:0] imem [128];
  string       itag [128];
  logic [31:0] dmem [64];

  assign imem_rdata = imem[imem_addr[8:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  pipe_core dut (
    .clk(clk), .rst_n(rst_n),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata),
    .dmem_we(dmem_we), .dmem_re(dmem_re), .dmem_rdata(dmem_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  int wp = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // ---------- encoders ----------
  function automatic logic [31:0] rr(input logic [5:0] fn, input int rd, input int s1, input int s2);
    return {6'h00, 5'(s1), 5'(s2), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] ii(input logic [5:0] op, input int rt, input int s1, input int imm);
    return {op, 5'(s1), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] jj(input int ofs);
    return {6'h02, 26'(ofs)};
  endfunction

  task automatic emit(input logic [31:0] w, input string t);
    imem[wp] = w;
    itag[wp] = t;
    wp++;
  endtask
  task automatic nops(input int n);
    for (int i = 0; i < n; i++) emit(32'h0, "R11");
  endtask

  // ---------- behavioural instruction model ----------
  logic [31:0] m_reg [32];
  logic [31:0] m_mem [64];
  logic [31:0] m_pc;
  int          m_cnt;
  logic [31:0] m_tgt;
  string       m_btag;
  bit          sv_v [4];
  logic [31:0] sv_a [4];
  logic [31:0] sv_d [4];
  string       sv_t [4];

  task automatic step();
    logic [31:0] ins, a, b, imm, nxt, ea;
    logic [5:0]  op, fn;
    int          s1, s2, rd;
    bit          taken;
    string       ptag;
    ptag = (m_cnt == 0 && m_btag != "") ? m_btag : "R2";
    check(imem_addr === m_pc, ptag, "fetch address", imem_addr, m_pc);
    m_btag = "";
    ins = imem[m_pc[8:2]];
    op = ins[31:26]; fn = ins[5:0];
    s1 = int'(ins[25:21]); s2 = int'(ins[20:16]); rd = int'(ins[15:11]);
    a = m_reg[s1]; b = m_reg[s2];
    imm = {{16{ins[15]}}, ins[15:0]};
    ea = a + imm;
    for (int k = 3; k > 0; k--) begin
      sv_v[k] = sv_v[k-1]; sv_a[k] = sv_a[k-1]; sv_d[k] = sv_d[k-1]; sv_t[k] = sv_t[k-1];
    end
    sv_v[0] = 1'b0;
    if (m_cnt == 1) nxt = m_tgt; else nxt = m_pc + 4;
    if (m_cnt > 0) m_cnt--;
    taken = 1'b0;
    case (op)
      6'h00: case (fn)
        6'h20: m_reg[rd] = a + b;
        6'h22: m_reg[rd] = a - b;
        6'h24: m_reg[rd] = a & b;
        6'h25: m_reg[rd] = a | b;
        6'h26: m_reg[rd] = a ^ b;
        6'h2A: m_reg[rd] = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
        default: ;
      endcase
      6'h08: m_reg[s2] = ea;
      6'h23: m_reg[s2] = m_mem[ea[7:2]];
      6'h2B: begin
        m_mem[ea[7:2]] = b;
        sv_v[0] = 1'b1; sv_a[0] = ea; sv_d[0] = b; sv_t[0] = itag[m_pc[8:2]];
      end
      6'h04: taken = (a == 0);
      6'h05: taken = (a != 0);
      6'h02: begin
        taken = 1'b1;
        imm = {{6{ins[25]}}, ins[25:0]};
      end
      default: ;
    endcase
    m_reg[0] = 32'h0;
    if (taken) begin
      m_cnt = 3; m_tgt = m_pc + 4 + imm; m_btag = itag[m_pc[8:2]];
    end
    m_pc = nxt;
    // outputs of the store fetched three cycles ago
    check(dmem_we === sv_v[3], sv_v[3] ? sv_t[3] : "R6", "store strobe", {31'd0, dmem_we}, {31'd0, sv_v[3]});
    if (sv_v[3] && dmem_we) begin
      check(dmem_addr === sv_a[3], sv_t[3], "store address", dmem_addr, sv_a[3]);
      check(dmem_wdata === sv_d[3], sv_t[3], "store data", dmem_wdata, sv_d[3]);
    end
    if (dmem_we) dmem[dmem_addr[7:2]] = dmem_wdata;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    int lp, bpos;
    for (int i = 0; i < 128; i++) begin imem[i] = '0; itag[i] = "R11"; end
    for (int i = 0; i < 64; i++) begin dmem[i] = '0; m_mem[i] = '0; end
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    m_pc = 0; m_cnt = 0; m_tgt = 0; m_btag = "";
    for (int k = 0; k < 4; k++) begin sv_v[k] = 0; sv_a[k] = 0; sv_d[k] = 0; sv_t[k] = ""; end

    // operands (R5: negative immediate)
    emit(ii(6'h08, 1, 0, 5), "R5");
    emit(ii(6'h08, 2, 0, -3), "R5");
    emit(ii(6'h08, 3, 0, 7), "R5");
    nops(2);
    // R3 / R4 register-type ops
    emit(rr(6'h20, 4, 1, 2), "R3");
    emit(rr(6'h22, 5, 1, 3), "R3");
    emit(rr(6'h24, 6, 1, 3), "R3");
    emit(rr(6'h25, 7, 1, 2), "R3");
    emit(rr(6'h26, 8, 1, 3), "R3");
    emit(rr(6'h2A, 9, 2, 1), "R4");
    emit(rr(6'h2A, 10, 1, 2), "R4");
    nops(2);
    emit(ii(6'h2B, 2, 0, 0), "R5");
    emit(ii(6'h2B, 4, 0, 4), "R3");
    emit(ii(6'h2B, 5, 0, 8), "R3");
    emit(ii(6'h2B, 6, 0, 12), "R3");
    emit(ii(6'h2B, 7, 0, 16), "R3");
    emit(ii(6'h2B, 8, 0, 20), "R3");
    emit(ii(6'h2B, 9, 0, 24), "R4");
    emit(ii(6'h2B, 10, 0, 28), "R4");
    // R9: write to register 0 discarded
    emit(ii(6'h08, 0, 0, 9), "R9");
    nops(2);
    emit(ii(6'h2B, 0, 0, 32), "R9");
    // R10: consumer exactly two slots behind producer
    emit(ii(6'h08, 12, 0, 16'h1234), "R10");
    nops(2);
    emit(ii(6'h2B, 12, 0, 36), "R10");
    // R6: load / store with negative displacement
    emit(ii(6'h08, 13, 0, 64), "R6");
    nops(2);
    emit(ii(6'h23, 14, 13, -28), "R6");
    nops(2);
    emit(ii(6'h2B, 14, 0, 40), "R6");
    emit(ii(6'h2B, 14, 13, -20), "R6");
    // R11: unassigned opcode and function code
    emit({6'h3F, 5'd0, 5'd1, 16'h0055}, "R11");
    emit(rr(6'h3F, 3, 1, 1), "R11");
    nops(2);
    emit(ii(6'h2B, 1, 0, 48), "R11");
    emit(ii(6'h2B, 3, 0, 52), "R11");
    // R7: BEQZ not taken
    emit(ii(6'h04, 0, 1, 64), "R7");
    nops(3);
    emit(ii(6'h08, 15, 0, 1), "R7");
    nops(2);
    emit(ii(6'h2B, 15, 0, 56), "R7");
    // R7: BEQZ taken, live first slot, skipped word before target
    emit(ii(6'h04, 0, 0, 16), "R7");
    emit(ii(6'h08, 16, 0, 11), "R7");
    nops(2);
    emit(ii(6'h08, 17, 0, 33), "R7");
    emit(ii(6'h2B, 16, 0, 60), "R7");
    emit(ii(6'h2B, 17, 0, 64), "R7");
    // R7: BNEZ backward loop, three passes
    emit(ii(6'h08, 18, 0, 3), "R7");
    nops(2);
    lp = wp;
    emit(ii(6'h08, 18, 18, -1), "R7");
    emit(ii(6'h08, 19, 19, 2), "R7");
    nops(1);
    bpos = wp;
    emit(ii(6'h05, 0, 18, lp*4 - (bpos*4 + 4)), "R7");
    nops(3);
    nops(1);
    emit(ii(6'h2B, 19, 0, 68), "R7");
    // R8: forward jump skips one word
    emit(jj(16), "R8");
    nops(3);
    emit(ii(6'h08, 20, 0, 99), "R8");
    emit(ii(6'h2B, 20, 0, 72), "R8");
    // R8: backward jump onto itself
    emit(jj(-4), "R8");
    nops(3);

    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      check(imem_addr === 32'h0, "R1", "fetch address in reset", imem_addr, 32'h0);
      check(dmem_we === 1'b0 && dmem_re === 1'b0, "R1", "memory strobes in reset",
            {30'd0, dmem_we, dmem_re}, 32'h0);
    end
    rst_n = 1'b1;
    for (int c = 0; c < 220; c++) begin
      step();
      @(negedge clk);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule